// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches a port of already-synchronised input pins and raises one combined interrupt line when any pin meets the condition chosen for it. Each pin can detect either a level or an edge. A level can be high or low. An edge can be rising, falling, or either direction. The choice is made by three per-pin configuration registers: one selects level or edge, one selects the polarity, and one overrides the polarity so that both edges count.

Edge events are latched in a sticky raw status bit. Software removes that bit by writing a one to the matching position of a write-one-to-clear register. A level-mode pin's raw status follows the pin and cannot be cleared. An enable mask gates the raw status into a masked status. The interrupt output is high whenever any masked bit is set.

Software reaches all registers through a simple synchronous register port. A write takes effect on the clock edge that samples it. Read data appears on the clock edge that samples the read request.

Top module: `pin_irq_detector`

## Requirements
- R1: Register SENSE (offset 0x404) chooses the mode per pin: bit value 1 means level detection, 0 means edge detection.
- R2: For a level-mode pin, raw status equals the pin when its POLARITY bit (offset 0x40C) is 1, and the inverted pin when it is 0. It is updated one clock after the pin is sampled, and a write to CLEAR has no effect on it.
- R3: For an edge-mode pin, a rising edge is detected when the POLARITY bit is 1 and a falling edge when it is 0. An edge is found by comparing the pin with its value one clock earlier, and it sets a raw status bit that stays set until cleared.
- R4: When a pin's ANYEDGE bit (offset 0x408) is 1, an edge-mode pin detects both rising and falling edges, and its POLARITY bit is ignored.
- R5: Masked status (offset 0x418) is raw status AND ENABLE (offset 0x410), where 1 unmasks a pin. The output irq_o is the OR of the masked bits and is registered.
- R6: Writing CLEAR (offset 0x41C) clears each latched edge status bit written as 1. Bits written as 0 are left as they are.
- R7: If an edge is detected on the same clock as a clear of that bit, the bit stays set.
- R8: Synchronous reset sets SENSE, ANYEDGE, POLARITY, ENABLE and raw status to zero, and drives irq_o low.
- R9: Reads return data on the clock after rd_en is sampled. Raw status sits at offset 0x414. Writes to raw status, masked status and any unmapped offset change nothing. CLEAR and unmapped offsets read as zero.
- R10: A pin change that happens while reset is asserted is not detected as an edge after reset is released, and a pulse lasting one clock is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | PINS | Synchronised pin values |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | PINS | Write data |
| rdata | output | PINS | Registered read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
A wrong mode or polarity bit, or a stale previous-pin sample, shows up as a raw status bit that reads wrong one clock after the pin is driven. Because the edge latch is sticky, that error stays visible until a clear is written. A faulty mask path or combining OR shows on irq_o one clock after the enable or status changes. The directed scenarios read raw and masked status after every stimulus, so a wrong bit is seen within two or three clocks. This includes the same-clock edge-and-clear collision and pin activity during reset.

// File: rtl/pid_pkg.sv
package pid_pkg;

  localparam int unsigned OFS_SENSE   = 'h404;
  localparam int unsigned OFS_ANYEDGE = 'h408;
  localparam int unsigned OFS_POLAR   = 'h40C;
  localparam int unsigned OFS_ENABLE  = 'h410;
  localparam int unsigned OFS_RAW     = 'h414;
  localparam int unsigned OFS_MASKED  = 'h418;
  localparam int unsigned OFS_CLEAR   = 'h41C;

  localparam int unsigned CFG_COUNT = 4;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_SENSE   = 3'd1,
    SEL_ANYEDGE = 3'd2,
    SEL_POLAR   = 3'd3,
    SEL_ENABLE  = 3'd4,
    SEL_RAW     = 3'd5,
    SEL_MASKED  = 3'd6,
    SEL_CLEAR   = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/pid_addr_decode.sv
module pid_addr_decode
  import pid_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFS_SENSE))   sel = SEL_SENSE;
    else if (addr == ADDR_W'(OFS_ANYEDGE)) sel = SEL_ANYEDGE;
    else if (addr == ADDR_W'(OFS_POLAR))   sel = SEL_POLAR;
    else if (addr == ADDR_W'(OFS_ENABLE))  sel = SEL_ENABLE;
    else if (addr == ADDR_W'(OFS_RAW))     sel = SEL_RAW;
    else if (addr == ADDR_W'(OFS_MASKED))  sel = SEL_MASKED;
    else if (addr == ADDR_W'(OFS_CLEAR))   sel = SEL_CLEAR;
  end

endmodule

// File: rtl/pid_cfg_regs.sv
module pid_cfg_regs
  import pid_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  reg_sel_e        sel,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] sense_o,
  output logic [PINS-1:0] anyedge_o,
  output logic [PINS-1:0] polar_o,
  output logic [PINS-1:0] enable_o
);

  logic [PINS-1:0] cfg_q [CFG_COUNT];

  // The four writable registers share one structure and differ only in
  // the select code that loads them (SEL_SENSE + index).
  for (genvar g = 0; g < CFG_COUNT; g++) begin : g_cfg
    localparam reg_sel_e MY_SEL = reg_sel_e'(3'(g + 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (wr_en && sel == MY_SEL) begin
        cfg_q[g] <= wdata;
      end
    end
  end

  assign sense_o   = cfg_q[0];
  assign anyedge_o = cfg_q[1];
  assign polar_o   = cfg_q[2];
  assign enable_o  = cfg_q[3];

  AST_ENABLE_ZERO_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enable_o == '0 && sense_o == '0)); // R8

endmodule

// File: rtl/pid_pin_detect.sv
module pid_pin_detect #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_i,
  input  logic [PINS-1:0] sense_i,
  input  logic [PINS-1:0] anyedge_i,
  input  logic [PINS-1:0] polar_i,
  input  logic [PINS-1:0] clr_i,
  output logic [PINS-1:0] raw_d_o,
  output logic [PINS-1:0] raw_q_o
);

  logic [PINS-1:0] pin_q;
  logic [PINS-1:0] hit;
  logic [PINS-1:0] raw_q;
  logic [PINS-1:0] raw_d;

  // Previous-pin sample keeps tracking the pins during reset so that
  // activity under reset never looks like an edge once reset drops.
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= pin_i;
    end else begin
      pin_q <= pin_i;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic rise;
    logic fall;
    logic lvl;

    always_comb begin
      rise   = pin_i[i] & ~pin_q[i];
      fall   = ~pin_i[i] & pin_q[i];
      lvl    = polar_i[i] ? pin_i[i] : ~pin_i[i];
      hit[i] = ~sense_i[i] & (anyedge_i[i] ? (rise | fall)
                                          : (polar_i[i] ? rise : fall));
      if (sense_i[i]) begin
        raw_d[i] = lvl;
      end else begin
        raw_d[i] = (raw_q[i] & ~clr_i[i]) | hit[i];
      end
    end

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      hit[i] |=> raw_q[i]); // R7

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
      (!sense_i[i] && raw_q[i] && !clr_i[i]) |=> raw_q[i]); // R3

    AST_CLEAR_DROPS_BIT: assert property (@(posedge clk) disable iff (rst)
      (!sense_i[i] && clr_i[i] && !hit[i]) |=> !raw_q[i]); // R6

    AST_LEVEL_TRACKS_PIN: assert property (@(posedge clk) disable iff (rst)
      sense_i[i] |=> (raw_q[i] == ($past(polar_i[i]) ? $past(pin_i[i])
                                                     : !$past(pin_i[i])))); // R2

    AST_ANYEDGE_CATCHES: assert property (@(posedge clk) disable iff (rst)
      (!sense_i[i] && anyedge_i[i] && (pin_i[i] != pin_q[i])) |=> raw_q[i]); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
    end else begin
      raw_q <= raw_d;
    end
  end

  assign raw_d_o = raw_d;
  assign raw_q_o = raw_q;

endmodule

// File: rtl/pid_read_mux.sv
module pid_read_mux
  import pid_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  reg_sel_e        sel,
  input  logic [PINS-1:0] sense_i,
  input  logic [PINS-1:0] anyedge_i,
  input  logic [PINS-1:0] polar_i,
  input  logic [PINS-1:0] enable_i,
  input  logic [PINS-1:0] raw_i,
  output logic [PINS-1:0] rdata_o
);

  logic [PINS-1:0] rd_mux;

  always_comb begin
    unique case (sel)
      SEL_SENSE:   rd_mux = sense_i;
      SEL_ANYEDGE: rd_mux = anyedge_i;
      SEL_POLAR:   rd_mux = polar_i;
      SEL_ENABLE:  rd_mux = enable_i;
      SEL_RAW:     rd_mux = raw_i;
      SEL_MASKED:  rd_mux = raw_i & enable_i;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en) begin
      rdata_o <= rd_mux;
    end
  end

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_o)); // R9

endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
  import pid_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   pin_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  output logic              irq_o
);

  reg_sel_e        sel;
  logic [PINS-1:0] sense;
  logic [PINS-1:0] anyedge;
  logic [PINS-1:0] polar;
  logic [PINS-1:0] enable;
  logic [PINS-1:0] clr;
  logic [PINS-1:0] raw_d;
  logic [PINS-1:0] raw_q;
  logic            irq_q;

  pid_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .sel  (sel)
  );

  pid_cfg_regs #(.PINS(PINS)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .sel       (sel),
    .wdata     (wdata),
    .sense_o   (sense),
    .anyedge_o (anyedge),
    .polar_o   (polar),
    .enable_o  (enable)
  );

  assign clr = (wr_en && sel == SEL_CLEAR) ? wdata : '0;

  pid_pin_detect #(.PINS(PINS)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (pin_i),
    .sense_i   (sense),
    .anyedge_i (anyedge),
    .polar_i   (polar),
    .clr_i     (clr),
    .raw_d_o   (raw_d),
    .raw_q_o   (raw_q)
  );

  pid_read_mux #(.PINS(PINS)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .sel       (sel),
    .sense_i   (sense),
    .anyedge_i (anyedge),
    .polar_i   (polar),
    .enable_i  (enable),
    .raw_i     (raw_q),
    .rdata_o   (rdata)
  );

  // Registered from next-state status so irq_o moves with raw status.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(raw_d & enable);
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_IS_MASKED_OR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == |(raw_q & $past(enable)))); // R5

endmodule

// File: tb/test_pin_irq_detector.sv
module test_pin_irq_detector;
  import pid_pkg::*;

  localparam int  PINS       = 8;
  localparam int  AW         = 12;
  localparam time CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PINS-1:0] pins = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [PINS-1:0] wdata = '0;
  logic [PINS-1:0] rdata;
  logic            irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  pin_irq_detector #(.PINS(PINS), .ADDR_W(AW)) i_pin_irq_detector (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pins),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq_o (irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string req, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(int unsigned ofs, logic [PINS-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(ofs); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(int unsigned ofs, output logic [PINS-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(ofs);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic expect_reg(string req, int unsigned ofs, logic [PINS-1:0] exp);
    logic [PINS-1:0] v;
    reg_rd(ofs, v);
    check(req, v, exp);
  endtask

  task automatic expect_irq(string req, logic exp);
    @(negedge clk);
    check(req, PINS'(irq), PINS'(exp));
  endtask

  task automatic set_pins(logic [PINS-1:0] v);
    @(negedge clk);
    pins = v;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    expect_reg("R8 sense", OFS_SENSE, '0);
    expect_reg("R8 anyedge", OFS_ANYEDGE, '0);
    expect_reg("R8 polarity", OFS_POLAR, '0);
    expect_reg("R8 enable", OFS_ENABLE, '0);
    expect_reg("R8 raw", OFS_RAW, '0);
    expect_reg("R8 masked", OFS_MASKED, '0);
    check("R8 irq", PINS'(irq), '0);
  endtask

  task automatic t_reg_map();
    reg_wr(OFS_POLAR, 8'h3C);
    expect_reg("R9 polarity readback", OFS_POLAR, 8'h3C);
    reg_wr(OFS_ANYEDGE, 8'h5A);
    expect_reg("R9 anyedge readback", OFS_ANYEDGE, 8'h5A);
    reg_wr(OFS_ENABLE, 8'hC3);
    expect_reg("R9 enable readback", OFS_ENABLE, 8'hC3);
    reg_wr(OFS_RAW, 8'hFF);
    expect_reg("R9 raw write ignored", OFS_RAW, 8'h00);
    reg_wr(OFS_MASKED, 8'hFF);
    expect_reg("R9 masked write ignored", OFS_MASKED, 8'h00);
    expect_reg("R9 clear reads zero", OFS_CLEAR, 8'h00);
    reg_wr('h420, 8'hFF);
    expect_reg("R9 unmapped reads zero", 'h420, 8'h00);
    expect_reg("R9 unmapped write no effect", OFS_SENSE, 8'h00);
    reg_wr(OFS_POLAR, '0);
    reg_wr(OFS_ANYEDGE, '0);
    reg_wr(OFS_ENABLE, '0);
  endtask

  task automatic t_level();
    reg_wr(OFS_POLAR, 8'h0F);
    reg_wr(OFS_SENSE, 8'hFF);
    expect_reg("R1 sense readback", OFS_SENSE, 8'hFF);
    expect_reg("R2 level, pins low", OFS_RAW, 8'hF0);
    set_pins(8'h55);
    expect_reg("R2 level, pins 0x55", OFS_RAW, 8'hA5);
    reg_wr(OFS_CLEAR, 8'hFF);
    expect_reg("R2 clear ignored in level mode", OFS_RAW, 8'hA5);
    set_pins(8'h00);
    expect_reg("R1 level follows pins back", OFS_RAW, 8'hF0);
    reg_wr(OFS_SENSE, 8'h00);
    reg_wr(OFS_CLEAR, 8'hFF);
    expect_reg("R1 edge mode holds no status", OFS_RAW, 8'h00);
    reg_wr(OFS_POLAR, 8'h00);
  endtask

  task automatic t_edge();
    reg_wr(OFS_POLAR, 8'h0F);
    set_pins(8'hFF);
    expect_reg("R3 rising on low nibble only", OFS_RAW, 8'h0F);
    set_pins(8'h00);
    expect_reg("R3 falling high nibble, sticky low", OFS_RAW, 8'hFF);
    reg_wr(OFS_CLEAR, 8'hFF);
    expect_reg("R3 cleared", OFS_RAW, 8'h00);
    reg_wr(OFS_POLAR, 8'h00);
  endtask

  task automatic t_both_edges();
    reg_wr(OFS_ANYEDGE, 8'h81);
    set_pins(8'h80);
    expect_reg("R4 rise with falling polarity", OFS_RAW, 8'h80);
    reg_wr(OFS_CLEAR, 8'hFF);
    reg_wr(OFS_POLAR, 8'hFF);
    set_pins(8'h00);
    expect_reg("R4 fall with rising polarity", OFS_RAW, 8'h80);
    reg_wr(OFS_CLEAR, 8'hFF);
    reg_wr(OFS_ANYEDGE, 8'h00);
    reg_wr(OFS_POLAR, 8'h00);
  endtask

  task automatic t_mask_clear();
    set_pins(8'h0F);
    set_pins(8'h00);
    expect_reg("R5 raw set", OFS_RAW, 8'h0F);
    expect_reg("R5 masked zero with enable zero", OFS_MASKED, 8'h00);
    expect_irq("R5 irq low while masked", 1'b0);
    reg_wr(OFS_ENABLE, 8'h10);
    expect_irq("R5 irq low, other bit enabled", 1'b0);
    reg_wr(OFS_ENABLE, 8'h04);
    expect_reg("R5 masked bit 2", OFS_MASKED, 8'h04);
    expect_irq("R5 irq high", 1'b1);
    reg_wr(OFS_CLEAR, 8'h04);
    expect_reg("R6 clear bit 2 only", OFS_RAW, 8'h0B);
    expect_irq("R6 irq low after clear", 1'b0);
    reg_wr(OFS_CLEAR, 8'h00);
    expect_reg("R6 zero write no effect", OFS_RAW, 8'h0B);
    reg_wr(OFS_CLEAR, 8'hFF);
    reg_wr(OFS_ENABLE, 8'h00);
  endtask

  task automatic t_edge_wins();
    reg_wr(OFS_POLAR, 8'hFF);
    set_pins(8'h02);
    set_pins(8'h00);
    expect_reg("R7 bit set before collision", OFS_RAW, 8'h02);
    @(negedge clk);
    pins = 8'h02; wr_en = 1'b1; addr = AW'(OFS_CLEAR); wdata = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    expect_reg("R7 edge wins over clear", OFS_RAW, 8'h02);
    reg_wr(OFS_CLEAR, 8'h02);
    expect_reg("R7 plain clear afterwards", OFS_RAW, 8'h00);
    @(negedge clk);
    pins = 8'h12;
    @(negedge clk);
    pins = 8'h02;
    expect_reg("R10 one-cycle pulse caught", OFS_RAW, 8'h10);
    set_pins(8'h00);
    reg_wr(OFS_CLEAR, 8'hFF);
    reg_wr(OFS_POLAR, 8'h00);
  endtask

  task automatic t_reset_activity();
    reg_wr(OFS_ENABLE, 8'hFF);
    set_pins(8'hFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    pins = 8'h00;
    @(negedge clk);
    rst = 1'b0;
    expect_reg("R10 no edge from reset-time change", OFS_RAW, 8'h00);
    expect_reg("R8 enable cleared by reset", OFS_ENABLE, 8'h00);
    expect_irq("R8 irq low after reset", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_reg_map();
    t_level();
    t_edge();
    t_both_edges();
    t_mask_clear();
    t_edge_wins();
    t_reset_activity();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule